// File: doc/BRIEF.md
# Nested-Disable Interrupt Controller

This block collects eight peripheral interrupt lines for a small processor core and hands the core one request at a time, together with the index of the chosen source. Each line is edge-captured into a pending bit. A per-source mask selects which pending bits may be delivered. When more than one of them qualifies, the source with the highest bit number wins.

Delivery as a whole is gated by a 5-bit nesting level rather than by a single on/off bit. Requests are delivered only while the level is zero. Software raises the level by writing a "hold" strobe and lowers it by writing a "release" strobe. The release strobe never takes the level below zero, and the hold strobe never takes it above 31. When the core accepts a request, the level rises by one on its own. A handler therefore ends by writing the release strobe.

The effective gating (the mask combined with a zero level) reaches delivery through a fixed six-stage pipeline. Any change to the mask or to the level affects delivery six cycles later.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset the request output is low, the index is 0, and reads of the mask (0x1A) and level (0x1D) return 0.
- R2: A write to address 0x1A stores the 8-bit mask, and a read of 0x1A returns it. A read of 0x1D returns the level zero-extended to 8 bits. A read of any other address, including 0x1B and 0x1C, returns 0.
- R3: A low-to-high transition on line i sets pending bit i. A line that stays high does not set it again. Pending bit i clears when a request with index i is accepted.
- R4: When several pending sources are enabled, the request carries the highest set bit number as its 3-bit binary index.
- R5: Once raised, the request and its index hold until the core pulses acknowledge. The request drops in the cycle after the acknowledge. An acknowledge while no request is raised has no effect on the level.
- R6: A write of any data to 0x1B raises the level by one, saturating at 31.
- R7: A write of any data to 0x1C lowers the level by one. At level 0 it leaves the level at 0.
- R8: An accepted request (acknowledge while the request is high) raises the level by one, saturating at 31.
- R9: An accepted request and a 0x1C write in the same cycle leave the level unchanged. A write to 0x1D loads the level from data bits 4:0 and overrides every other change in that cycle.
- R10: A source is delivered only if its mask bit is set and the level is zero, both as they stood six cycles earlier. After a write at clock edge t opens the gate for a pending source, the request rises at edge t+7 and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronous to clk |
| irq_lines | input | 8 | Peripheral interrupt lines, edge-captured |
| bus_addr | input | 8 | Register address |
| bus_we | input | 1 | Write strobe for the current address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address (combinational) |
| core_req | output | 1 | Interrupt request to the core |
| core_idx | output | 3 | Index of the requested source |
| core_ack | input | 1 | Acknowledge pulse from the core |

## Verification
The bench targets the exact edge at which an opened gate first lets a request through. A pipeline that is one stage short or one stage long would raise the request a cycle early or a cycle late. It drives both ends of the level: a design that wraps would release all interrupts at 31 plus one, and a design that underflows would lock them out at 0 minus one. It also drives the acknowledge that coincides with a release write, where a design that does not cancel the two would drift the level. The bench holds a line high across an acceptance, which a level-sensitive capture would answer with a repeat request. It raises several sources at once and checks that the highest bit wins, which catches a priority encoder wired the wrong way round. It acknowledges with no request pending, which a design that counts every acknowledge would turn into a stuck disable.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  localparam int NSRC     = 8;
  localparam int IDX_W    = $clog2(NSRC);
  localparam int LVL_W    = 5;
  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 8;
  localparam int GATE_DLY = 6;

  localparam logic [ADDR_W-1:0] REG_MASK    = 8'h1A;
  localparam logic [ADDR_W-1:0] REG_HOLD    = 8'h1B;
  localparam logic [ADDR_W-1:0] REG_RELEASE = 8'h1C;
  localparam logic [ADDR_W-1:0] REG_LEVEL   = 8'h1D;

  typedef struct packed {
    logic mask_wr;
    logic hold_wr;
    logic rel_wr;
    logic lvl_wr;
  } bus_dec_t;
endpackage

// File: rtl/irq_pend_latch.sv
module irq_pend_latch #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] lines,
  input  logic [NSRC-1:0] clr,
  output logic [NSRC-1:0] pend
);
  logic [NSRC-1:0] prev_q;
  logic [NSRC-1:0] pend_q;
  logic [NSRC-1:0] pend_d;
  logic [NSRC-1:0] rise;

  always_comb begin
    rise   = lines & ~prev_q;
    pend_d = (pend_q & ~clr) | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= lines;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;

  AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((pend_q & $past(rise)) == $past(rise))); // R3
  AST_PEND_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr & ~rise) != '0) |=> ((pend_q & $past(clr & ~rise)) == '0)); // R3
  AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr)); // R3
endmodule

// File: rtl/irq_nest_cnt.sv
module irq_nest_cnt #(
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_wr,
  input  logic             accept,
  input  logic             rel_wr,
  input  logic             ld,
  input  logic [LVL_W-1:0] ld_val,
  output logic [LVL_W-1:0] lvl
);
  localparam int SW = LVL_W + 1;
  localparam logic [SW-1:0]    LMAX_W = {1'b0, {LVL_W{1'b1}}};
  localparam logic [LVL_W-1:0] LMAX   = {LVL_W{1'b1}};

  logic [LVL_W-1:0] lvl_q;
  logic [LVL_W-1:0] lvl_d;
  logic             lvl_en;
  logic [1:0]       n_up;
  logic [1:0]       step;
  logic [SW-1:0]    sum;

  always_comb begin
    n_up   = {1'b0, hold_wr} + {1'b0, accept};
    step   = n_up - {1'b0, rel_wr};
    sum    = {1'b0, lvl_q} + SW'(step);
    lvl_en = ld | hold_wr | accept | rel_wr;
    lvl_d  = lvl_q;
    if (ld) begin
      lvl_d = ld_val;
    end else if (rel_wr && (n_up == 2'd0)) begin
      lvl_d = (lvl_q == '0) ? '0 : lvl_q - 1'b1;
    end else if (n_up > {1'b0, rel_wr}) begin
      lvl_d = (sum > LMAX_W) ? LMAX : sum[LVL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
    end else if (lvl_en) begin
      lvl_q <= lvl_d;
    end
  end

  assign lvl = lvl_q;

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q == LMAX) && !ld && !rel_wr |=> (lvl_q == LMAX)); // R6
  AST_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q == '0) && rel_wr && !hold_wr && !accept && !ld |=> (lvl_q == '0)); // R7
  AST_ACK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !hold_wr && !rel_wr && !ld && (lvl_q != LMAX)
      |=> (lvl_q == $past(lvl_q) + 1'b1)); // R8
  AST_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    accept && rel_wr && !hold_wr && !ld |=> $stable(lvl_q)); // R9
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (lvl_q == $past(ld_val))); // R9
endmodule

// File: rtl/irq_gate_pipe.sv
module irq_gate_pipe #(
  parameter int W      = 8,
  parameter int STAGES = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg[0] <= '0;
    end else begin
      stg[0] <= d;
    end
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg[g] <= '0;
      end else begin
        stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int NSRC  = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  cand,
  input  logic             ack,
  output logic             req,
  output logic [IDX_W-1:0] idx,
  output logic             accept
);
  logic             req_q;
  logic             req_d;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] best;
  logic             any;
  logic             take;

  always_comb begin
    best = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (cand[i]) best = IDX_W'(i);
    end
    any    = |cand;
    take   = !req_q && any;
    accept = req_q && ack;
    req_d  = req_q;
    if (accept) req_d = 1'b0;
    else if (take) req_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      idx_q <= '0;
    end else begin
      req_q <= req_d;
      if (take) idx_q <= best;
    end
  end

  assign req = req_q;
  assign idx = idx_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_q && !ack |=> req_q && $stable(idx_q)); // R5
  AST_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    req_q && ack |=> !req_q); // R5
  AST_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_q && (cand != '0) |=> req_q); // R10
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irq_nest_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_lines,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              core_req,
  output logic [IDX_W-1:0]  core_idx,
  input  logic              core_ack
);
  bus_dec_t        dec;
  logic [NSRC-1:0] mask_q;
  logic [LVL_W-1:0] lvl;
  logic [NSRC-1:0] gate_now;
  logic [NSRC-1:0] gate_dly;
  logic [NSRC-1:0] pend;
  logic [NSRC-1:0] cand;
  logic [NSRC-1:0] clr;
  logic            accept;

  always_comb begin
    dec.mask_wr = bus_we && (bus_addr == REG_MASK);
    dec.hold_wr = bus_we && (bus_addr == REG_HOLD);
    dec.rel_wr  = bus_we && (bus_addr == REG_RELEASE);
    dec.lvl_wr  = bus_we && (bus_addr == REG_LEVEL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (dec.mask_wr) begin
      mask_q <= bus_wdata[NSRC-1:0];
    end
  end

  always_comb begin
    case (bus_addr)
      REG_MASK:  bus_rdata = DATA_W'(mask_q);
      REG_LEVEL: bus_rdata = DATA_W'(lvl);
      default:   bus_rdata = '0;
    endcase
  end

  always_comb begin
    gate_now = (lvl == '0) ? mask_q : '0;
    cand     = pend & gate_dly;
    clr      = accept ? (NSRC'(1) << core_idx) : '0;
  end

  irq_pend_latch #(.NSRC(NSRC)) u_pend (
    .clk   (clk),
    .rst_n (rst_n),
    .lines (irq_lines),
    .clr   (clr),
    .pend  (pend)
  );

  irq_nest_cnt #(.LVL_W(LVL_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold_wr (dec.hold_wr),
    .accept  (accept),
    .rel_wr  (dec.rel_wr),
    .ld      (dec.lvl_wr),
    .ld_val  (bus_wdata[LVL_W-1:0]),
    .lvl     (lvl)
  );

  irq_gate_pipe #(.W(NSRC), .STAGES(GATE_DLY)) u_gate (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (gate_now),
    .q     (gate_dly)
  );

  irq_pick #(.NSRC(NSRC), .IDX_W(IDX_W)) u_pick (
    .clk    (clk),
    .rst_n  (rst_n),
    .cand   (cand),
    .ack    (core_ack),
    .req    (core_req),
    .idx    (core_idx),
    .accept (accept)
  );

  AST_IDLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == REG_HOLD) || (bus_addr == REG_RELEASE) |-> (bus_rdata == '0)); // R2
  AST_REQ_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_req) |-> $past(cand != '0)); // R10
endmodule

// File: tb/irq_nest_ctrl_tb.sv
`timescale 1ns/1ps
module irq_nest_ctrl_tb;
  logic       clk;
  logic       rst_n;
  logic [7:0] irq_lines;
  logic [7:0] bus_addr;
  logic       bus_we;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       core_req;
  logic [2:0] core_idx;
  logic       core_ack;

  int    n_chk = 0;
  int    n_err = 0;
  bit    done  = 0;
  string phase = "R1";

  irq_nest_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .core_req(core_req), .core_idx(core_idx), .core_ack(core_ack)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // behavioural reference
  logic [7:0] m_en, m_pend, m_prev;
  int         m_lvl;
  logic [7:0] m_gate [6];
  logic       m_req;
  logic [2:0] m_idx;

  function automatic int top_bit(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) if (v[i]) return i;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_pend = 0; m_prev = 0; m_lvl = 0; m_req = 0; m_idx = 0;
      for (int k = 0; k < 6; k++) m_gate[k] = 0;
    end else begin
      logic acc;
      logic [7:0] cand, rise, clr, g0;
      int up, dn, net;
      acc  = core_ack && m_req;
      rise = irq_lines & ~m_prev;
      clr  = acc ? (8'd1 << m_idx) : 8'd0;
      cand = m_pend & m_gate[5];
      g0   = (m_lvl == 0) ? m_en : 8'd0;
      if (m_req) begin
        if (core_ack) m_req = 0;
      end else if (cand != 0) begin
        m_req = 1; m_idx = 3'(top_bit(cand));
      end
      m_pend = (m_pend & ~clr) | rise;
      m_prev = irq_lines;
      up = (bus_we && bus_addr == 8'h1B) ? 1 : 0;
      dn = (bus_we && bus_addr == 8'h1C) ? 1 : 0;
      if (bus_we && bus_addr == 8'h1D) m_lvl = int'(bus_wdata) % 32;
      else begin
        net = up + (acc ? 1 : 0) - dn;
        if (net < 0) m_lvl = (m_lvl > 0) ? m_lvl - 1 : 0;
        else m_lvl = (m_lvl + net > 31) ? 31 : m_lvl + net;
      end
      if (bus_we && bus_addr == 8'h1A) m_en = bus_wdata;
      for (int k = 5; k > 0; k--) m_gate[k] = m_gate[k-1];
      m_gate[0] = g0;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int m_rd(input logic [7:0] a);
    if (a == 8'h1A) return int'(m_en);
    if (a == 8'h1D) return m_lvl;
    return 0;
  endfunction

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      check(core_req === m_req, {phase, " req"}, int'(core_req), int'(m_req));
      check(core_idx === m_idx, {phase, " idx"}, int'(core_idx), int'(m_idx));
      check(int'(bus_rdata) == m_rd(bus_addr), {phase, " rdata"}, int'(bus_rdata), m_rd(bus_addr));
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic ack_pulse();
    core_ack = 1'b1;
    @(posedge clk); @(negedge clk);
    core_ack = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input int exp, input string tag);
    bus_addr = a; bus_we = 1'b0;
    #1;
    check(int'(bus_rdata) == exp, tag, int'(bus_rdata), exp);
  endtask

  task automatic req_chk(input bit r, input int i, input string tag);
    #1;
    check(core_req == r, {tag, " req"}, int'(core_req), int'(r));
    if (r) check(int'(core_idx) == i, {tag, " idx"}, int'(core_idx), i);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [15:0] lf;
    rst_n = 0; irq_lines = 0; bus_addr = 0; bus_we = 0; bus_wdata = 0; core_ack = 0;
    tick(3);
    rst_n = 1;
    // R1 reset state
    phase = "R1";
    req_chk(0, 0, "R1");
    rd_chk(8'h1A, 0, "R1 mask");
    rd_chk(8'h1D, 0, "R1 level");
    // R2 register map
    phase = "R2";
    tick();
    wr(8'h1A, 8'hA5);
    rd_chk(8'h1A, 8'hA5, "R2 mask readback");
    rd_chk(8'h1B, 0, "R2 hold reads 0");
    rd_chk(8'h1C, 0, "R2 release reads 0");
    rd_chk(8'h40, 0, "R2 unmapped reads 0");
    tick();
    wr(8'h1A, 8'h00);
    tick(8);
    // R10 delivery timing
    phase = "R10";
    irq_lines[2] = 1'b1;
    tick(3);
    wr(8'h1A, 8'h04);
    tick(6);
    req_chk(0, 0, "R10 not before t+7");
    tick();
    req_chk(1, 2, "R10 at t+7");
    // R8 acceptance raises level
    phase = "R8";
    ack_pulse();
    rd_chk(8'h1D, 1, "R8 level after accept");
    req_chk(0, 0, "R5 drop after ack");
    // R3 held line does not re-pend
    phase = "R3";
    wr(8'h1C, 0);
    tick(10);
    req_chk(0, 0, "R3 level-held line");
    irq_lines = 0;
    // R4 priority
    phase = "R4";
    wr(8'h1A, 8'hFF);
    wr(8'h1B, 0);
    tick(8);
    irq_lines = 8'h62;
    tick(2);
    wr(8'h1C, 0);
    tick(7);
    req_chk(1, 6, "R4 highest wins");
    // R5 hold until ack
    phase = "R5";
    tick(5);
    req_chk(1, 6, "R5 held");
    wr(8'h1B, 0);
    tick(10);
    req_chk(1, 6, "R5 held while gate closes");
    ack_pulse();
    rd_chk(8'h1D, 2, "R8 level after second accept");
    phase = "R4";
    wr(8'h1C, 0);
    wr(8'h1C, 0);
    tick(7);
    req_chk(1, 5, "R4 next highest");
    // R9 ack and release cancel
    phase = "R9";
    bus_addr = 8'h1C; bus_we = 1'b1; core_ack = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0; core_ack = 1'b0;
    rd_chk(8'h1D, 0, "R9 cancel");
    tick(3);
    req_chk(1, 1, "R4 lowest remaining");
    ack_pulse();
    rd_chk(8'h1D, 1, "R8 level one");
    phase = "R5";
    ack_pulse();
    rd_chk(8'h1D, 1, "R5 stray ack ignored");
    // R6 saturation
    phase = "R6";
    wr(8'h1D, 8'd30);
    rd_chk(8'h1D, 30, "R9 direct load");
    wr(8'h1B, 0);
    rd_chk(8'h1D, 31, "R6 to max");
    wr(8'h1B, 0);
    rd_chk(8'h1D, 31, "R6 saturate");
    // R7 floor
    phase = "R7";
    wr(8'h1D, 8'hE1);
    rd_chk(8'h1D, 1, "R9 load uses low bits");
    wr(8'h1C, 0);
    rd_chk(8'h1D, 0, "R7 to zero");
    wr(8'h1C, 0);
    rd_chk(8'h1D, 0, "R7 floor");
    // mixed traffic against the model
    phase = "R10 mixed";
    irq_lines = 0;
    lf = 16'hACE1;
    for (int c = 0; c < 3000; c++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      irq_lines = lf[7:0] ^ lf[15:8];
      core_ack  = lf[3] & lf[9];
      bus_we    = (lf[5:4] != 2'b00);
      case (lf[12:10])
        3'd0, 3'd1: bus_addr = 8'h1B;
        3'd2, 3'd3, 3'd4: bus_addr = 8'h1C;
        3'd5: bus_addr = 8'h1A;
        3'd6: bus_addr = 8'h1D;
        default: bus_addr = 8'h30;
      endcase
      bus_wdata = lf[15:8];
      if (bus_addr == 8'h1D) bus_wdata = {5'd0, lf[2:0] & 3'd1};
      @(posedge clk); @(negedge clk);
    end
    bus_we = 0; core_ack = 0;
    tick(2);
    finish_run();
  end
endmodule